// File: doc/BRIEF.md
# Disk Adapter Command Sequencer

This block runs one command on a fixed-disk adapter, acting for the host. It drives the adapter's register interface directly and follows a fixed order. It waits until the adapter reports neither busy nor a pending interrupt. It writes an attention request, then writes each command word, waiting for the adapter to take each word before writing the next. It then enables the interrupt and waits for it. It compares the returned interrupt code with the code that this command should produce, and acts on the result.

Four operations are supported. Two are short query commands (device parameters and adapter configuration). After a successful query, the sequencer reads a requested number of status words into a small local store and then acknowledges the interrupt. The other two are block transfers (read and write). After the adapter reports that the transfer is ready, the sequencer pulses a DMA-start strobe and waits for a second interrupt with DMA enabled. It then acknowledges and checks the completion code. A wrong code at the first interrupt leads to an abort request and one more interrupt wait. A failed transfer is retried a bounded number of times.

Top module: `disk_cmd_seq`

## Requirements
- R1: The attention output is written only when both busy and interrupt-pending were low in the preceding cycle. The attention value is the device number shifted left by 5, ORed with the code: 0x01 issues a command, 0x02 ends the interrupt, 0x03 aborts.
- R2: A query command writes two words. The first is its opcode ORed with the device number in bits 7:5: 0x0609 for parameters (op=2) and 0x060A for configuration (op=3). The second word is zero.
- R3: A transfer command writes four words: the opcode (0x4601 read op=0, 0x4602 write op=1) ORed with the device in bits 7:5, the sector count, the low 16 address bits, and the high 16 address bits. Each word is written only after command-full was seen low.
- R4: Every interrupt wait enables the interrupt by writing 0x01 to the control output, or 0x03 during the DMA phase. Once the interrupt arrives, the block writes 0x00 to the control output.
- R5: The expected code at the first interrupt is the device field ORed with 0x01 for a query and ORed with 0x0B for a transfer.
- R6: On an unexpected first code, the block sends the abort attention and waits for one more interrupt. It then ends with an error, unless a transfer retry applies (R9).
- R7: A successful query reads exactly the requested number of status words, each after status-full was seen high. It stores word k at index k, readable with one cycle of latency, and then sends the end-of-interrupt attention.
- R8: A successful transfer pulses dma_go once, waits for the second interrupt, and then sends end-of-interrupt. A completion code with low nibble of 8 or less gives done.
- R9: A failed transfer is retried from the attention step, with at most 4 attempts in total. A completion low nibble of 0xC (bad sector) ends the command with an error at once.
- R10: A start request while active is ignored. done and err are single-cycle pulses, and only one of them is raised per command.
- R11: After reset all strobes, done, err and active are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (sampled when idle) |
| op | input | 2 | 0 read, 1 write, 2 parameters, 3 configuration |
| dev | input | 3 | Device number |
| sec_count | input | 16 | Sector count for transfers |
| sec_addr | input | 32 | Sector address for transfers |
| nstat | input | 5 | Status words to read after a query |
| ad_busy | input | 1 | Adapter busy |
| ad_int_pend | input | 1 | Adapter interrupt pending |
| ad_cmd_full | input | 1 | Command register not yet taken |
| ad_stat_full | input | 1 | Status word available |
| ad_irq | input | 1 | Interrupt strobe |
| ad_irq_code | input | 8 | Interrupt status code valid with ad_irq |
| ad_stat_word | input | 16 | Status word from adapter |
| att_we | output | 1 | Attention write strobe |
| att_val | output | 8 | Attention value |
| cmd_we | output | 1 | Command word write strobe |
| cmd_word | output | 16 | Command word |
| ctl_we | output | 1 | Control write strobe |
| ctl_val | output | 8 | Control value |
| stat_re | output | 1 | Status word read strobe |
| dma_go | output | 1 | Start DMA for the transfer |
| active | output | 1 | A command is running |
| done | output | 1 | Command completed pulse |
| err | output | 1 | Command failed pulse |
| stat_idx | input | 4 | Status store read index |
| stat_data | output | 16 | Status store read data |

## Verification
The hardest case to reach from the ports is the retry path. In that path a transfer completes its DMA phase with a bad code and then runs again from the attention step, or fails at the first interrupt several times in a row until the attempt limit ends it. The bench's adapter model answers each interrupt enable from a scripted list of codes, so a test can fix the exact sequence of ready, failure, abort and bad-sector codes. The model also holds busy, interrupt-pending and command-full for several cycles after each access, which makes every handshake wait actually stall.

// File: rtl/disk_seq_pkg.sv
package disk_seq_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_PARAMS = 2'd2, OP_CONFIG = 2'd3} op_e;
  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_DMA = 2'd1, PH_ABT = 2'd2} phase_e;

  localparam logic [7:0] ATT_REQ   = 8'h01;
  localparam logic [7:0] ATT_EOI   = 8'h02;
  localparam logic [7:0] ATT_ABORT = 8'h03;

  localparam logic [15:0] OPC_READ   = 16'h4601;
  localparam logic [15:0] OPC_WRITE  = 16'h4602;
  localparam logic [15:0] OPC_PARAMS = 16'h0609;
  localparam logic [15:0] OPC_CONFIG = 16'h060A;

  localparam logic [7:0] IRQ_CMD_OK   = 8'h01;
  localparam logic [7:0] IRQ_XFER_RDY = 8'h0B;

  localparam logic [7:0] CTL_OFF = 8'h00;
  localparam logic [7:0] CTL_IRQ = 8'h01;
  localparam logic [7:0] CTL_DMA = 8'h03;

  function automatic logic is_xfer(op_e o);
    return (o == OP_READ) || (o == OP_WRITE);
  endfunction
endpackage

// File: rtl/disk_cmd_words.sv
module disk_cmd_words
  import disk_seq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int DEV_W     = 3,
  parameter int DEV_SHIFT = 5
) (
  input  op_e                 op,
  input  logic [DEV_W-1:0]    dev,
  input  logic [WORD_W-1:0]   count,
  input  logic [2*WORD_W-1:0] addr,
  input  logic [1:0]          idx,
  output logic [WORD_W-1:0]   word,
  output logic [2:0]          nwords
);
  logic [WORD_W-1:0] opc;
  logic [WORD_W-1:0] dev_bits;

  assign dev_bits = WORD_W'({dev, {DEV_SHIFT{1'b0}}});

  always_comb begin
    unique case (op)
      OP_READ:   opc = WORD_W'(OPC_READ);
      OP_WRITE:  opc = WORD_W'(OPC_WRITE);
      OP_PARAMS: opc = WORD_W'(OPC_PARAMS);
      default:   opc = WORD_W'(OPC_CONFIG);
    endcase
  end

  assign nwords = is_xfer(op) ? 3'd4 : 3'd2;

  always_comb begin
    word = '0;
    unique case (idx)
      2'd0: word = opc | dev_bits;
      2'd1: word = is_xfer(op) ? count : '0;
      2'd2: word = addr[WORD_W-1:0];
      default: word = addr[2*WORD_W-1:WORD_W];
    endcase
  end
endmodule

// File: rtl/disk_stat_ram.sv
module disk_stat_ram #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/disk_try_ctr.sv
module disk_try_ctr #(
  parameter int MAX_TRIES = 4,
  localparam int TW       = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [TW-1:0] used;

  always_ff @(posedge clk) begin
    if (rst || clr) used <= '0;
    else if (inc)   used <= used + TW'(1);
  end

  assign last = (used == TW'(MAX_TRIES - 1));
endmodule

// File: rtl/disk_cmd_seq.sv
module disk_cmd_seq
  import disk_seq_pkg::*;
#(
  parameter int DEV_W      = 3,
  parameter int DEV_SHIFT  = 5,
  parameter int WORD_W     = 16,
  parameter int STAT_DEPTH = 16,
  parameter int MAX_TRIES  = 4,
  parameter logic [3:0] BAD_NIB  = 4'hC,
  parameter logic [3:0] OK_LIMIT = 4'd8,
  localparam int SIDX_W    = $clog2(STAT_DEPTH),
  localparam int NSTAT_W   = SIDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [DEV_W-1:0]     dev,
  input  logic [WORD_W-1:0]    sec_count,
  input  logic [2*WORD_W-1:0]  sec_addr,
  input  logic [NSTAT_W-1:0]   nstat,
  input  logic                 ad_busy,
  input  logic                 ad_int_pend,
  input  logic                 ad_cmd_full,
  input  logic                 ad_stat_full,
  input  logic                 ad_irq,
  input  logic [7:0]           ad_irq_code,
  input  logic [WORD_W-1:0]    ad_stat_word,
  output logic                 att_we,
  output logic [7:0]           att_val,
  output logic                 cmd_we,
  output logic [WORD_W-1:0]    cmd_word,
  output logic                 ctl_we,
  output logic [7:0]           ctl_val,
  output logic                 stat_re,
  output logic                 dma_go,
  output logic                 active,
  output logic                 done,
  output logic                 err,
  input  logic [SIDX_W-1:0]    stat_idx,
  output logic [WORD_W-1:0]    stat_data
);
  typedef enum logic [3:0] {
    S_IDLE, S_ATT, S_GAP, S_CMD_POLL, S_ARM, S_WAIT,
    S_CHECK, S_STAT, S_FINISH, S_FAIL
  } st_e;

  st_e                 st, ret_q;
  op_e                 op_q;
  phase_e              phase_q;
  logic [DEV_W-1:0]    dev_q;
  logic [WORD_W-1:0]   cnt_q;
  logic [2*WORD_W-1:0] addr_q;
  logic [NSTAT_W-1:0]  nstat_q, sidx;
  logic [2:0]          widx;
  logic [7:0]          att_code_q, code_q;

  logic [WORD_W-1:0]   word_nx;
  logic [2:0]          nwords;
  logic [7:0]          dev_field, exp_code;
  logic                xfer, bad_sector, final_bad, last_try, can_retry;
  logic                try_clr, try_inc, ram_we;

  assign dev_field  = 8'({dev_q, {DEV_SHIFT{1'b0}}});
  assign xfer       = is_xfer(op_q);
  assign exp_code   = dev_field | (xfer ? IRQ_XFER_RDY : IRQ_CMD_OK);
  assign bad_sector = (code_q[3:0] == BAD_NIB);
  assign final_bad  = (code_q[3:0] > OK_LIMIT);
  assign can_retry  = xfer && !last_try && !((phase_q == PH_DMA) && bad_sector);
  assign active     = (st != S_IDLE);

  assign try_clr = (st == S_IDLE) && start;
  assign try_inc = (st == S_FAIL) && can_retry;
  assign ram_we  = (st == S_STAT) && (sidx != nstat_q) && ad_stat_full;

  disk_cmd_words #(.WORD_W(WORD_W), .DEV_W(DEV_W), .DEV_SHIFT(DEV_SHIFT)) i_words (
    .op(op_q), .dev(dev_q), .count(cnt_q), .addr(addr_q),
    .idx(widx[1:0]), .word(word_nx), .nwords(nwords)
  );

  disk_stat_ram #(.WORD_W(WORD_W), .DEPTH(STAT_DEPTH)) i_ram (
    .clk(clk), .we(ram_we), .waddr(sidx[SIDX_W-1:0]), .wdata(ad_stat_word),
    .raddr(stat_idx), .rdata(stat_data)
  );

  disk_try_ctr #(.MAX_TRIES(MAX_TRIES)) i_tries (
    .clk(clk), .rst(rst), .clr(try_clr), .inc(try_inc), .last(last_try)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ret_q      <= S_IDLE;
      op_q       <= OP_READ;
      phase_q    <= PH_CMD;
      dev_q      <= '0;
      cnt_q      <= '0;
      addr_q     <= '0;
      nstat_q    <= '0;
      sidx       <= '0;
      widx       <= '0;
      att_code_q <= '0;
      code_q     <= '0;
      att_we     <= 1'b0;
      att_val    <= '0;
      cmd_we     <= 1'b0;
      cmd_word   <= '0;
      ctl_we     <= 1'b0;
      ctl_val    <= '0;
      stat_re    <= 1'b0;
      dma_go     <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      att_we  <= 1'b0;
      cmd_we  <= 1'b0;
      ctl_we  <= 1'b0;
      stat_re <= 1'b0;
      dma_go  <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            op_q       <= op_e'(op);
            dev_q      <= dev;
            cnt_q      <= sec_count;
            addr_q     <= sec_addr;
            nstat_q    <= (nstat > NSTAT_W'(STAT_DEPTH)) ? NSTAT_W'(STAT_DEPTH) : nstat;
            widx       <= '0;
            phase_q    <= PH_CMD;
            att_code_q <= ATT_REQ;
            ret_q      <= S_CMD_POLL;
            st         <= S_ATT;
          end
        end
        S_ATT: begin
          if (!ad_busy && !ad_int_pend) begin
            att_we  <= 1'b1;
            att_val <= dev_field | att_code_q;
            st      <= S_GAP;
          end
        end
        S_GAP: st <= ret_q;
        S_CMD_POLL: begin
          if (!ad_cmd_full) begin
            if (widx == nwords) begin
              st <= S_ARM;
            end else begin
              cmd_we   <= 1'b1;
              cmd_word <= word_nx;
              widx     <= widx + 3'd1;
              ret_q    <= S_CMD_POLL;
              st       <= S_GAP;
            end
          end
        end
        S_ARM: begin
          ctl_we  <= 1'b1;
          ctl_val <= (phase_q == PH_DMA) ? CTL_DMA : CTL_IRQ;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          if (ad_irq) begin
            code_q  <= ad_irq_code;
            ctl_we  <= 1'b1;
            ctl_val <= CTL_OFF;
            st      <= S_CHECK;
          end
        end
        S_CHECK: begin
          unique case (phase_q)
            PH_CMD: begin
              if (code_q != exp_code) begin
                phase_q    <= PH_ABT;
                att_code_q <= ATT_ABORT;
                ret_q      <= S_ARM;
                st         <= S_ATT;
              end else if (xfer) begin
                dma_go  <= 1'b1;
                phase_q <= PH_DMA;
                st      <= S_ARM;
              end else begin
                sidx <= '0;
                st   <= S_STAT;
              end
            end
            PH_DMA: begin
              att_code_q <= ATT_EOI;
              ret_q      <= S_FINISH;
              st         <= S_ATT;
            end
            default: st <= S_FAIL;
          endcase
        end
        S_STAT: begin
          if (sidx == nstat_q) begin
            att_code_q <= ATT_EOI;
            ret_q      <= S_FINISH;
            st         <= S_ATT;
          end else if (ad_stat_full) begin
            stat_re <= 1'b1;
            sidx    <= sidx + NSTAT_W'(1);
            ret_q   <= S_STAT;
            st      <= S_GAP;
          end
        end
        S_FINISH: begin
          if ((phase_q == PH_DMA) && final_bad) begin
            st <= S_FAIL;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_FAIL: begin
          if (can_retry) begin
            phase_q    <= PH_CMD;
            widx       <= '0;
            att_code_q <= ATT_REQ;
            ret_q      <= S_CMD_POLL;
            st         <= S_ATT;
          end else begin
            err <= 1'b1;
            st  <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/disk_cmd_seq_chk.sv
module disk_cmd_seq_chk #(
  parameter int WORD_W = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       ad_busy,
  input logic       ad_int_pend,
  input logic       ad_cmd_full,
  input logic       ad_stat_full,
  input logic       ad_irq,
  input logic       att_we,
  input logic       cmd_we,
  input logic       ctl_we,
  input logic [7:0] ctl_val,
  input logic       stat_re,
  input logic       done,
  input logic       err
);
  a_r1_att_when_idle: assert property (@(posedge clk) disable iff (rst)
    att_we |-> $past(!ad_busy && !ad_int_pend));

  a_r3_word_after_clear: assert property (@(posedge clk) disable iff (rst)
    cmd_we |-> $past(!ad_cmd_full));

  a_r4_off_after_irq: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_val == 8'h00) |-> $past(ad_irq));

  a_r7_read_when_full: assert property (@(posedge clk) disable iff (rst)
    stat_re |-> $past(ad_stat_full));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  a_r10_not_both: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
endmodule

bind disk_cmd_seq disk_cmd_seq_chk #(.WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_disk_cmd_seq.sv
module test_disk_cmd_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [2:0]  dev = 3'd0;
  logic [15:0] sec_count = '0;
  logic [31:0] sec_addr = '0;
  logic [4:0]  nstat = '0;
  logic [3:0]  stat_idx = '0;
  logic        ad_busy, ad_int_pend, ad_cmd_full, ad_stat_full, ad_irq;
  logic [7:0]  ad_irq_code;
  logic [15:0] ad_stat_word;
  logic        att_we, cmd_we, ctl_we, stat_re, dma_go, active, done, err;
  logic [7:0]  att_val, ctl_val;
  logic [15:0] cmd_word, stat_data;

  disk_cmd_seq i_disk_cmd_seq (.*);

  // adapter model
  logic       log_clr = 1'b0;
  logic [7:0] codes [8];
  int busy_cnt, ip_cnt, cf_cnt, irq_cnt, sgap, sptr, cptr;
  logic       prev_idle_bad, prev_cf;
  logic [7:0]  att_log [16];
  logic [15:0] cmd_log [32];
  logic [7:0]  ctl_log [32];
  int n_att, n_cmd, n_ctl, n_dma, n_done, n_err, n_srd, n_irq, viol;

  assign ad_busy      = busy_cnt != 0;
  assign ad_int_pend  = ip_cnt != 0;
  assign ad_cmd_full  = cf_cnt != 0;
  assign ad_stat_word = 16'hA000 + 16'(sptr);

  always @(posedge clk) begin
    if (rst || log_clr) begin
      busy_cnt <= 0; ip_cnt <= 0; cf_cnt <= 0; irq_cnt <= 0; sgap <= 2;
      sptr <= 0; cptr <= 0; ad_stat_full <= 1'b0; ad_irq <= 1'b0;
      ad_irq_code <= '0; prev_idle_bad <= 1'b0; prev_cf <= 1'b0;
      n_att <= 0; n_cmd <= 0; n_ctl <= 0; n_dma <= 0; n_done <= 0;
      n_err <= 0; n_srd <= 0; n_irq <= 0; viol <= 0;
    end else begin
      prev_idle_bad <= ad_busy || ad_int_pend;
      prev_cf       <= ad_cmd_full;
      ad_irq        <= 1'b0;
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (ip_cnt != 0)   ip_cnt   <= ip_cnt - 1;
      if (cf_cnt != 0)   cf_cnt   <= cf_cnt - 1;
      if (att_we) begin
        if (n_att < 16) att_log[n_att] <= att_val;
        n_att <= n_att + 1;
        busy_cnt <= 3;
        if (prev_idle_bad) viol <= viol + 1;
      end
      if (cmd_we) begin
        if (n_cmd < 32) cmd_log[n_cmd] <= cmd_word;
        n_cmd <= n_cmd + 1;
        cf_cnt <= 3;
        if (prev_cf) viol <= viol + 1;
      end
      if (ctl_we) begin
        if (n_ctl < 32) ctl_log[n_ctl] <= ctl_val;
        n_ctl <= n_ctl + 1;
        if (ctl_val != 8'h00) irq_cnt <= 5;
      end else if (irq_cnt != 0) begin
        irq_cnt <= irq_cnt - 1;
        if (irq_cnt == 1) begin
          ad_irq <= 1'b1;
          ad_irq_code <= codes[cptr % 8];
          cptr <= cptr + 1;
          ip_cnt <= 4;
          n_irq <= n_irq + 1;
        end
      end
      if (stat_re) begin
        ad_stat_full <= 1'b0; sgap <= 2; sptr <= sptr + 1; n_srd <= n_srd + 1;
      end else if (sgap != 0) sgap <= sgap - 1;
      else ad_stat_full <= 1'b1;
      if (dma_go) n_dma <= n_dma + 1;
      if (done)   n_done <= n_done + 1;
      if (err)    n_err <= n_err + 1;
    end
  end

  int checks = 0;
  int fails = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic prep(input logic [7:0] c0, c1, c2, c3, c4, c5, c6, c7);
    codes[0] = c0; codes[1] = c1; codes[2] = c2; codes[3] = c3;
    codes[4] = c4; codes[5] = c5; codes[6] = c6; codes[7] = c7;
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic launch(input logic [1:0] o, input logic [2:0] d,
                        input logic [15:0] c, input logic [31:0] a, input logic [4:0] n);
    @(negedge clk);
    op = o; dev = d; sec_count = c; sec_addr = a; nstat = n; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_wait(input string req);
    int t = 0;
    while (n_done + n_err == 0 && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) chk({req, " timeout"}, 1, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_stat(input int k, input logic [15:0] exp);
    @(negedge clk); stat_idx = 4'(k);
    @(negedge clk);
    chk("R7 status word", stat_data, exp);
  endtask

  task automatic t_reset;
    chk("R11 att_we", att_we, 0); chk("R11 cmd_we", cmd_we, 0);
    chk("R11 ctl_we", ctl_we, 0); chk("R11 done", done, 0);
    chk("R11 err", err, 0); chk("R11 active", active, 0);
    chk("R11 dma_go", dma_go, 0);
  endtask

  task automatic t_params;
    prep(8'h21, 0, 0, 0, 0, 0, 0, 0);
    launch(2'd2, 3'd1, 16'h0, 32'h0, 5'd3);
    finish_wait("R7");
    chk("R1 att count", n_att, 2); chk("R1 att cmd", att_log[0], 8'h21);
    chk("R1 att eoi", att_log[1], 8'h22);
    chk("R2 word count", n_cmd, 2); chk("R2 word0", cmd_log[0], 16'h0629);
    chk("R2 word1", cmd_log[1], 0);
    chk("R4 ctl count", n_ctl, 2); chk("R4 ctl on", ctl_log[0], 8'h01);
    chk("R4 ctl off", ctl_log[1], 8'h00);
    chk("R7 reads", n_srd, 3);
    chk("R5 done", n_done, 1); chk("R5 err", n_err, 0);
    chk("R1 handshake", viol, 0);
    read_stat(0, 16'hA000); read_stat(1, 16'hA001); read_stat(2, 16'hA002);
  endtask

  task automatic t_config;
    prep(8'hE1, 0, 0, 0, 0, 0, 0, 0);
    launch(2'd3, 3'd7, 16'h0, 32'h0, 5'd2);
    finish_wait("R2");
    chk("R2 config word0", cmd_log[0], 16'h06EA);
    chk("R1 config att", att_log[0], 8'hE1);
    chk("R7 config reads", n_srd, 2);
    chk("R5 config done", n_done, 1);
    read_stat(1, 16'hA001);
    prep(8'h01, 0, 0, 0, 0, 0, 0, 0);
    launch(2'd2, 3'd0, 16'h0, 32'h0, 5'd0);
    finish_wait("R7");
    chk("R7 zero reads", n_srd, 0); chk("R7 zero eoi", att_log[1], 8'h02);
    chk("R7 zero done", n_done, 1);
  endtask

  task automatic t_mismatch;
    prep(8'h25, 8'h23, 0, 0, 0, 0, 0, 0);
    launch(2'd2, 3'd1, 16'h0, 32'h0, 5'd3);
    finish_wait("R6");
    chk("R6 att count", n_att, 2); chk("R6 abort", att_log[1], 8'h23);
    chk("R6 ctl count", n_ctl, 4); chk("R6 rearm", ctl_log[2], 8'h01);
    chk("R6 irqs", n_irq, 2); chk("R6 err", n_err, 1); chk("R6 done", n_done, 0);
    chk("R6 no reads", n_srd, 0);
  endtask

  task automatic t_read;
    prep(8'h0B, 8'h08, 0, 0, 0, 0, 0, 0);
    launch(2'd0, 3'd0, 16'd8, 32'h0012_3456, 5'd0);
    repeat (10) @(negedge clk);
    chk("R10 active", active, 1);
    start = 1'b1; op = 2'd1; dev = 3'd3;
    @(negedge clk); start = 1'b0;
    finish_wait("R8");
    chk("R3 words", n_cmd, 4); chk("R3 w0", cmd_log[0], 16'h4601);
    chk("R3 w1", cmd_log[1], 16'd8); chk("R3 w2", cmd_log[2], 16'h3456);
    chk("R3 w3", cmd_log[3], 16'h0012);
    chk("R4 dma ctl", ctl_log[2], 8'h03); chk("R4 ctl count", n_ctl, 4);
    chk("R8 dma_go", n_dma, 1); chk("R8 eoi", att_log[1], 8'h02);
    chk("R10 one done", n_done, 1); chk("R10 att count", n_att, 2);
    chk("R10 idle", active, 0); chk("R3 handshake", viol, 0);
  endtask

  task automatic t_retry_ok;
    prep(8'h2B, 8'h29, 8'h2B, 8'h28, 0, 0, 0, 0);
    launch(2'd1, 3'd1, 16'd2, 32'hABCD_0010, 5'd0);
    finish_wait("R9");
    chk("R9 words", n_cmd, 8); chk("R3 write w0", cmd_log[4], 16'h4622);
    chk("R3 write w3", cmd_log[7], 16'hABCD);
    chk("R9 att count", n_att, 4); chk("R9 dma", n_dma, 2);
    chk("R9 done", n_done, 1); chk("R9 err", n_err, 0);
  endtask

  task automatic t_exhaust;
    prep(8'h4A, 8'h40, 8'h4A, 8'h40, 8'h4A, 8'h40, 8'h4A, 8'h40);
    launch(2'd1, 3'd2, 16'd1, 32'h0000_0100, 5'd0);
    finish_wait("R9");
    chk("R9 attempts att", n_att, 8); chk("R6 abort dev2", att_log[1], 8'h43);
    chk("R9 attempts words", n_cmd, 16); chk("R9 exhaust err", n_err, 1);
    chk("R9 exhaust dma", n_dma, 0); chk("R9 exhaust done", n_done, 0);
  endtask

  task automatic t_bad;
    prep(8'h0B, 8'h0C, 8'h0B, 8'h08, 0, 0, 0, 0);
    launch(2'd0, 3'd0, 16'd4, 32'h0000_0200, 5'd0);
    finish_wait("R9");
    chk("R9 bad att", n_att, 2); chk("R9 bad words", n_cmd, 4);
    chk("R9 bad dma", n_dma, 1); chk("R9 bad err", n_err, 1);
    chk("R9 bad done", n_done, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_params();
    t_config();
    t_mismatch();
    t_read();
    t_retry_ok();
    t_exhaust();
    t_bad();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule